// File: doc/BRIEF.md
# Configurable Two-Flip-Flop Logic Cell

This block is one logic cell of a programmable array. Five logic inputs feed a function generator built from two 4-input lookup tables. The generator can produce two independent functions, F and G. It can also join both tables through a multiplexer steered by the fifth input to form any Boolean function of all five inputs. Two flip-flops each load F, G or a direct data bit. They share a clock enable, a clock whose active edge is chosen by configuration, and a clear that takes effect at once.

Each of the two outputs shows either its flip-flop or its combinational function. Every choice comes from a static parallel configuration word, which must only change while the cell is held clear.

Top module: `cfg_logic_cell`

## Requirements
- R1: With the wide-mode bit (cfg[41]) at 0, F equals cfg[15:0] indexed by {d,c,b,a}, and G equals cfg[31:16] indexed by {e,d,c,b}. The rightmost input is index bit 0, and lin[0]=a through lin[4]=e.
- R2: With cfg[41] at 1, F and G both equal the G table cfg[31:16] indexed by {d,c,b,a} when e is 1, and the F table cfg[15:0] indexed by {d,c,b,a} when e is 0.
- R3: Each flip-flop loads its selected source on the active clock edge. Flip-flop X uses the field cfg[33:32] and flip-flop Y uses cfg[35:34]. Code 0 selects F, code 1 selects G, and codes 2 and 3 select din.
- R4: With cfg[38] at 0 the flip-flops update on the rising edge of clk. With cfg[38] at 1 they update on the falling edge.
- R5: With cfg[39] at 1 and ce low, both flip-flops keep their state whatever the data and function inputs do. With cfg[39] at 0, ce has no effect and the flip-flops load on every active edge.
- R6: With cfg[40] at 1, arst high clears both flip-flops at once and keeps them clear over any clocked load. With cfg[40] at 0, arst has no effect.
- R7: rst_n low or cfg_busy high clears both flip-flops at once.
- R8: After the last clear source goes away, the flip-flops stay at 0 through two active edges and load data first on the third.
- R9: out_x shows flip-flop X when cfg[36] is 1 and F when it is 0. out_y shows flip-flop Y when cfg[37] is 1 and G when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock before polarity selection |
| rst_n | input | 1 | Chip-wide clear, active low |
| cfg_busy | input | 1 | High while configuration is being loaded; clears the flip-flops |
| cfg | input | 42 | Static configuration word |
| lin | input | 5 | Logic inputs a (bit 0) to e (bit 4) |
| din | input | 1 | Direct data input to the flip-flops |
| ce | input | 1 | Shared clock enable, active high |
| arst | input | 1 | Cell asynchronous clear, active high |
| out_x | output | 1 | Selected X output |
| out_y | output | 1 | Selected Y output |

## Verification
Two functions can meet in one cycle: a clocked load that the enable permits, and the cell clear. The bench raises arst with the enable on and a 1 at din for both flip-flops. The outputs must read 0 at the sample after that edge, and the data must appear only on the third edge after the clear is dropped. The same pairing is repeated with the clear-use bit at 0, where the load must win. A second overlap puts a low enable on an edge while the inputs change. Here the bench expects the previous state, and the scoreboard model decides each case from the requirements alone.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LUT_K     = 4;
  localparam int LUT_BITS  = 1 << LUT_K;
  localparam int NUM_IN    = LUT_K + 1;
  localparam int NUM_FF    = 2;
  localparam int SRC_W     = 2;
  localparam int SYNC_DEPTH = 2;
  localparam int CFG_W     = 2 * LUT_BITS + NUM_FF * SRC_W + NUM_FF + 4;

  typedef enum logic [SRC_W-1:0] {
    SRC_FN_F = 2'd0,
    SRC_FN_G = 2'd1,
    SRC_DIN  = 2'd2,
    SRC_DIN2 = 2'd3
  } src_e;

  // Packed MSB first: lut_f occupies the low bits of the word.
  typedef struct packed {
    logic                wide;
    logic                rst_use;
    logic                ce_use;
    logic                clk_inv;
    logic                osel_y;
    logic                osel_x;
    src_e                src_y;
    src_e                src_x;
    logic [LUT_BITS-1:0] lut_g;
    logic [LUT_BITS-1:0] lut_f;
  } cell_cfg_t;
endpackage

// File: rtl/lc_lut.sv
module lc_lut #(
  parameter int K = 4,
  localparam int DEPTH = 1 << K
) (
  input  logic [DEPTH-1:0] tab,
  input  logic [K-1:0]     idx,
  output logic             bit_o
);
  always_comb begin
    bit_o = tab[idx];
  end
endmodule

// File: rtl/lc_funcgen.sv
module lc_funcgen
  import lc_pkg::*;
(
  input  logic [LUT_BITS-1:0] tab_f,
  input  logic [LUT_BITS-1:0] tab_g,
  input  logic [NUM_IN-1:0]   lin,
  input  logic                wide,
  output logic                fn_f,
  output logic                fn_g
);
  localparam int HI_LO = NUM_IN - LUT_K;

  logic [LUT_K-1:0] idx_lo;
  logic [LUT_K-1:0] idx_hi;
  logic [LUT_K-1:0] idx_g;
  logic             raw_f;
  logic             raw_g;
  logic             joined;

  always_comb begin
    idx_lo = lin[LUT_K-1:0];
    idx_hi = lin[NUM_IN-1:HI_LO];
    idx_g  = wide ? idx_lo : idx_hi;
  end

  lc_lut #(.K(LUT_K)) u_lut_f (.tab(tab_f), .idx(idx_lo), .bit_o(raw_f));
  lc_lut #(.K(LUT_K)) u_lut_g (.tab(tab_g), .idx(idx_g),  .bit_o(raw_g));

  always_comb begin
    joined = lin[NUM_IN-1] ? raw_g : raw_f;
    fn_f   = wide ? joined : raw_f;
    fn_g   = wide ? joined : raw_g;
  end
endmodule

// File: rtl/lc_ffpair.sv
module lc_ffpair
  import lc_pkg::*;
(
  input  logic                        cell_clk,
  input  logic                        clr_async_n,
  input  logic                        ce_eff,
  input  logic [NUM_FF-1:0][SRC_W-1:0] src,
  input  logic                        fn_f,
  input  logic                        fn_g,
  input  logic                        din,
  output logic [NUM_FF-1:0]           q,
  output logic                        clr_sync_n
);
  logic [SYNC_DEPTH-1:0] sync_q;
  logic [SYNC_DEPTH-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[SYNC_DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge cell_clk or negedge clr_async_n) begin
    if (!clr_async_n) sync_q <= '0;
    else              sync_q <= sync_nxt;
  end

  assign clr_sync_n = sync_q[SYNC_DEPTH-1];

  for (genvar i = 0; i < NUM_FF; i++) begin : g_ff
    logic pick;
    logic nxt;
    logic q_r;

    always_comb begin
      case (src_e'(src[i]))
        SRC_FN_F: pick = fn_f;
        SRC_FN_G: pick = fn_g;
        default:  pick = din;
      endcase
      nxt = ce_eff ? pick : q_r;
    end

    always_ff @(posedge cell_clk or negedge clr_sync_n) begin
      if (!clr_sync_n) q_r <= 1'b0;
      else             q_r <= nxt;
    end

    assign q[i] = q_r;
  end
endmodule

// File: rtl/lc_outsel.sv
module lc_outsel #(
  parameter int N = 2
) (
  input  logic [N-1:0] comb_v,
  input  logic [N-1:0] reg_v,
  input  logic [N-1:0] use_reg,
  output logic [N-1:0] out_v
);
  for (genvar i = 0; i < N; i++) begin : g_sel
    always_comb begin
      out_v[i] = use_reg[i] ? reg_v[i] : comb_v[i];
    end
  end
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import lc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_busy,
  input  logic [CFG_W-1:0]  cfg,
  input  logic [NUM_IN-1:0] lin,
  input  logic              din,
  input  logic              ce,
  input  logic              arst,
  output logic              out_x,
  output logic              out_y
);
  cell_cfg_t                   c;
  logic                        cell_clk;
  logic                        ce_eff;
  logic                        clr_async_n;
  logic                        clr_sync_n;
  logic                        fn_f;
  logic                        fn_g;
  logic [NUM_FF-1:0]           q;
  logic                        qx;
  logic                        qy;
  logic [NUM_FF-1:0][SRC_W-1:0] src;
  logic [NUM_FF-1:0]           outs;

  always_comb begin
    c           = cell_cfg_t'(cfg);
    cell_clk    = clk ^ c.clk_inv;
    ce_eff      = !c.ce_use || ce;
    clr_async_n = rst_n && !cfg_busy && !(c.rst_use && arst);
    src[0]      = c.src_x;
    src[1]      = c.src_y;
  end

  lc_funcgen u_fg (
    .tab_f (c.lut_f),
    .tab_g (c.lut_g),
    .lin   (lin),
    .wide  (c.wide),
    .fn_f  (fn_f),
    .fn_g  (fn_g)
  );

  lc_ffpair u_ff (
    .cell_clk    (cell_clk),
    .clr_async_n (clr_async_n),
    .ce_eff      (ce_eff),
    .src         (src),
    .fn_f        (fn_f),
    .fn_g        (fn_g),
    .din         (din),
    .q           (q),
    .clr_sync_n  (clr_sync_n)
  );

  assign qx = q[0];
  assign qy = q[1];

  lc_outsel #(.N(NUM_FF)) u_os (
    .comb_v  ({fn_g, fn_f}),
    .reg_v   (q),
    .use_reg ({c.osel_y, c.osel_x}),
    .out_v   (outs)
  );

  assign out_x = outs[0];
  assign out_y = outs[1];
endmodule

// File: rtl/lc_checker.sv
module lc_checker
  import lc_pkg::*;
(
  input logic              cell_clk,
  input logic              rst_n,
  input logic              cfg_busy,
  input logic [CFG_W-1:0]  cfg,
  input logic [NUM_IN-1:0] lin,
  input logic              din,
  input logic              ce,
  input logic              arst,
  input logic              clr_sync_n,
  input logic              qx,
  input logic              qy,
  input logic              out_x
);
  cell_cfg_t k;
  assign k = cell_cfg_t'(cfg);

  // R6: an enabled cell clear wins over any clocked load
  assert_arst_clears_R6: assert property (@(posedge cell_clk) disable iff (!rst_n)
    (k.rst_use && arst) |-> (qx == 1'b0 && qy == 1'b0));

  // R7: configuration in progress keeps both flip-flops at zero
  assert_busy_clears_R7: assert property (@(posedge cell_clk) disable iff (!rst_n)
    cfg_busy |-> (qx == 1'b0 && qy == 1'b0));

  // R5: a low enable in use freezes both flip-flops
  assert_ce_hold_R5: assert property (@(posedge cell_clk) disable iff (!clr_sync_n)
    (k.ce_use && !ce) |=> ($stable(qx) && $stable(qy)));

  // R3: direct-data source lands in flip-flop X one edge later
  assert_din_capture_R3: assert property (@(posedge cell_clk) disable iff (!clr_sync_n)
    ((!k.ce_use || ce) && (k.src_x == SRC_DIN || k.src_x == SRC_DIN2)) |=> (qx == $past(din)));

  // R2: joined five-input function seen on out_x in combinational mode
  assert_wide_fn_R2: assert property (@(posedge cell_clk) disable iff (!rst_n)
    (k.wide && !k.osel_x) |-> (out_x == (lin[4] ? k.lut_g[lin[3:0]] : k.lut_f[lin[3:0]])));
endmodule

bind cfg_logic_cell lc_checker u_chk (
  .cell_clk   (cell_clk),
  .rst_n      (rst_n),
  .cfg_busy   (cfg_busy),
  .cfg        (cfg),
  .lin        (lin),
  .din        (din),
  .ce         (ce),
  .arst       (arst),
  .clr_sync_n (clr_sync_n),
  .qx         (qx),
  .qy         (qy),
  .out_x      (out_x)
);

// File: tb/sim_cfg_logic_cell.sv
module sim_cfg_logic_cell;
  localparam int CW = 42;

  logic          clk;
  logic          rst_n;
  logic          cfg_busy;
  logic [CW-1:0] cfg;
  logic [4:0]    lin;
  logic          din;
  logic          ce;
  logic          arst;
  logic          out_x;
  logic          out_y;

  cfg_logic_cell u0 (
    .clk(clk), .rst_n(rst_n), .cfg_busy(cfg_busy), .cfg(cfg), .lin(lin),
    .din(din), .ce(ce), .arst(arst), .out_x(out_x), .out_y(out_y)
  );

  typedef struct {
    bit   chk;
    logic ex;
    logic ey;
    int   req;
  } exp_t;

  exp_t          sb[$];
  int            n_tests = 0;
  int            n_fail  = 0;
  logic [CW-1:0] ncfg;
  logic          nrst;
  logic          nbusy;
  logic          qxm, qym;
  int            scnt;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [CW-1:0] mk_cfg(logic [15:0] lf, logic [15:0] lg,
      logic [1:0] sx, logic [1:0] sy, logic ox, logic oy, logic inv,
      logic ceu, logic rstu, logic wide);
    return {wide, rstu, ceu, inv, oy, ox, sy, sx, lg, lf};
  endfunction

  function automatic logic ref_f(logic [CW-1:0] c, logic [4:0] v);
    if (c[41]) return v[4] ? c[16 + int'(v[3:0])] : c[int'(v[3:0])];
    return c[int'(v[3:0])];
  endfunction

  function automatic logic ref_g(logic [CW-1:0] c, logic [4:0] v);
    if (c[41]) return v[4] ? c[16 + int'(v[3:0])] : c[int'(v[3:0])];
    return c[16 + int'(v[4:1])];
  endfunction

  function automatic logic pick(logic [1:0] s, logic f, logic g, logic d);
    if (s == 2'd0) return f;
    if (s == 2'd1) return g;
    return d;
  endfunction

  // Driver: applies inputs away from the edge and pushes the expected outputs
  task automatic step(input logic [4:0] v, input logic d, input logic e,
                      input logic a, input int req, input bit chk);
    logic fx, gy, clr;
    exp_t it;
    @(posedge clk);
    #2;
    rst_n = nrst; cfg_busy = nbusy; cfg = ncfg;
    lin = v; din = d; ce = e; arst = a;
    fx  = ref_f(ncfg, v);
    gy  = ref_g(ncfg, v);
    clr = !nrst || nbusy || (ncfg[40] && a);
    if (clr) begin
      qxm = 1'b0; qym = 1'b0; scnt = 0;
    end else if (scnt < 2) begin
      scnt++;
    end else if (!ncfg[39] || e) begin
      qxm = pick(ncfg[33:32], fx, gy, d);
      qym = pick(ncfg[35:34], fx, gy, d);
    end
    it.chk = chk;
    it.ex  = ncfg[36] ? qxm : fx;
    it.ey  = ncfg[37] ? qym : gy;
    it.req = req;
    sb.push_back(it);
  endtask

  // R4: peek between the falling and the next rising edge
  task automatic probe(input logic d);
    logic old, expv;
    old = qxm;
    step(5'd0, d, 1'b1, 1'b0, 4, 1'b1);
    #5;
    expv = ncfg[38] ? qxm : old;
    n_tests++;
    if (out_x !== expv) begin
      n_fail++;
      $display("FAIL R4 edge probe: out_x=%b expected %b", out_x, expv);
    end
  endtask

  // Monitor: pops one expectation per cycle and compares the outputs
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        if (it.chk) begin
          n_tests++;
          if (out_x !== it.ex || out_y !== it.ey) begin
            n_fail++;
            $display("FAIL R%0d: out_x/out_y=%b%b expected %b%b",
                     it.req, out_x, out_y, it.ex, it.ey);
          end
        end
      end
    end
  end

  initial begin
    #2_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_busy = 1'b0; lin = '0; din = 1'b0; ce = 1'b0; arst = 1'b0;
    nrst = 1'b0; nbusy = 1'b0; qxm = 1'b0; qym = 1'b0; scnt = 0;
    // Reset state: flip-flops shown on both outputs, expected zero (R7)
    ncfg = mk_cfg(16'h6996, 16'h8000, 2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    cfg  = ncfg;
    for (int i = 0; i < 3; i++) step(5'd31, 1'b1, 1'b1, 1'b0, 7, 1'b1);

    // R1: split functions, combinational view
    nrst = 1'b1;
    ncfg = mk_cfg(16'h6996, 16'h8000, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) step(5'((i * 7 + 3) % 32), 1'b0, 1'b1, 1'b0, 1, 1'b1);
    step(5'd30, 1'b0, 1'b1, 1'b0, 1, 1'b1);

    // R2: joined five-input function, every input pattern
    ncfg = mk_cfg(16'hFFFE, 16'h0001, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 32; i++) step(5'(i), 1'b0, 1'b1, 1'b0, 2, 1'b1);

    // R3 and R9: source selection seen through the flip-flop outputs
    ncfg = mk_cfg(16'h6996, 16'h8000, 2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) step(5'(i * 5), 1'(i % 3 == 0), 1'b1, 1'b0, 3, 1'b1);
    ncfg = mk_cfg(16'h6996, 16'h8000, 2'd1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step(5'(30 + i % 2), 1'(i % 2), 1'b1, 1'b0, 3, 1'b1);
    ncfg = mk_cfg(16'h6996, 16'h8000, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step(5'(i * 3), 1'(i % 2), 1'b1, 1'b0, 9, 1'b1);

    // R5: enable in use; low enable holds while inputs move
    ncfg = mk_cfg(16'h6996, 16'h8000, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step(5'd1, 1'b1, 1'b1, 1'b0, 5, 1'b1);
    for (int i = 0; i < 4; i++) step(5'(i * 6), 1'(i % 2), 1'b0, 1'b0, 5, 1'b1);
    step(5'd0, 1'b0, 1'b1, 1'b0, 5, 1'b1);
    ncfg = mk_cfg(16'h6996, 16'h8000, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(5'd1, 1'b1, 1'b0, 1'b0, 5, 1'b1);
    step(5'd3, 1'b0, 1'b0, 1'b0, 5, 1'b1);

    // R6 and R8: clear meets an enabled load, then synchronous release
    ncfg = mk_cfg(16'hFFFF, 16'hFFFF, 2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    step(5'd0, 1'b1, 1'b1, 1'b0, 6, 1'b1);
    step(5'd0, 1'b1, 1'b1, 1'b1, 6, 1'b1);
    step(5'd0, 1'b1, 1'b1, 1'b1, 6, 1'b1);
    for (int i = 0; i < 4; i++) step(5'd0, 1'b1, 1'b1, 1'b0, 8, 1'b1);
    // R6: clear not in use, arst ignored
    ncfg = mk_cfg(16'hFFFF, 16'hFFFF, 2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step(5'd0, 1'b0, 1'b1, 1'b1, 6, 1'b1);
    step(5'd0, 1'b1, 1'b1, 1'b1, 6, 1'b1);
    step(5'd0, 1'b1, 1'b1, 1'b1, 6, 1'b1);

    // R7: configuration in progress clears, then release via R8
    nbusy = 1'b1;
    step(5'd0, 1'b1, 1'b1, 1'b0, 7, 1'b1);
    step(5'd0, 1'b1, 1'b1, 1'b0, 7, 1'b1);
    nbusy = 1'b0;
    for (int i = 0; i < 4; i++) step(5'd0, 1'b1, 1'b1, 1'b0, 8, 1'b1);

    // R4: falling-edge mode, polarity changed only while held clear
    nrst = 1'b0;
    ncfg = mk_cfg(16'h6996, 16'h8000, 2'd2, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(5'd0, 1'b0, 1'b1, 1'b0, 4, 1'b1);
    nrst = 1'b1;
    for (int i = 0; i < 3; i++) step(5'd0, 1'b0, 1'b1, 1'b0, 4, 1'b1);
    probe(1'b1);
    probe(1'b0);
    probe(1'b1);
    // R4: back to rising-edge mode
    nrst = 1'b0;
    ncfg = mk_cfg(16'h6996, 16'h8000, 2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(5'd0, 1'b0, 1'b1, 1'b0, 4, 1'b1);
    nrst = 1'b1;
    for (int i = 0; i < 3; i++) step(5'd0, 1'b0, 1'b1, 1'b0, 4, 1'b1);
    probe(1'b1);
    probe(1'b0);

    repeat (3) @(posedge clk);
    #3;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule